// File: doc/BRIEF.md
# Paired-Byte Register File Read Restorer

This block holds a small register file in which neighbouring registers share
their unused upper bytes. A register whose value is narrow keeps redundant copies
of its partner's bytes in its high lanes. The read port has to hide this. It
takes a read address and fetches the raw stored row, the stored length tag and
the stored sign flag. It then builds the architectural value one byte lane at a
time.

Each lane picks one of four sources: the raw byte in the same lane, the raw byte
from the mirrored lane, all zeros, or all ones. Lanes within the effective length
carry data. Lanes above it carry the sign fill, whatever the cells hold. Rows at
odd addresses are stored with their byte lanes mirrored for routing, and reads
undo that mirroring. A configuration input picks where the sign comes from: the
stored sign flag, or the top bit of the most significant meaningful byte.

The block has no state machine. Its only sequential parts are the storage array
and one output register stage.

Top module: `nw_rf_read_restore`

## Requirements
- R1: After reset every row reads as zero, and `rd_valid` is low until the first read.
- R2: The length tag L (0 to 3) means logical bytes 0..L are meaningful. Output byte k, for k <= L, equals logical byte k of the stored row.
- R3: Output bytes above L are 8'h00 for a non-negative value and 8'hFF for a negative one, whatever the stored lanes contain.
- R4: With `cfg_sign_derived`=0 the sign is the flag `wr_neg` stored at write time.
- R5: With `cfg_sign_derived`=1 the sign is bit 7 of logical byte L. For consistently written values both modes give the same data.
- R6: At odd addresses, physical lane j (bits 8j+7:8j) holds logical byte 3-j. At even addresses lane j holds logical byte j. Reads undo the mirroring.
- R7: `rd_data` and `rd_valid` update one clock after `rd_en`. Without `rd_en`, `rd_valid` goes low and `rd_data` holds.
- R8: A read at the same edge as a write to the same address returns the contents before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address |
| wr_row | input | 32 | Raw physical row to store |
| wr_len | input | 2 | Length tag (meaningful bytes minus one) |
| wr_neg | input | 1 | Stored sign flag |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Read address |
| cfg_sign_derived | input | 1 | 1: derive the sign from the data; 0: use the stored flag |
| rd_data | output | 32 | Restored architectural value |
| rd_valid | output | 1 | Read result valid |

## Verification
The bench stores rows whose upper lanes hold unrelated bytes. A design that passed raw lanes through instead of forcing the fill would return that unrelated data. Mirrored rows at odd addresses catch a design that skips the mirroring, because such a design returns bytes in swapped order. One row stores a sign flag that disagrees with the data, so the two sign modes must give different fills; a design with the sign source wired wrong returns the same value in both modes. A write and a read to one address at the same edge show whether the design forwards the new data when it should return the old.

// File: rtl/nw_rf_pkg.sv
package nw_rf_pkg;
    typedef enum logic [1:0] {
        SRC_DIRECT = 2'd0,
        SRC_MIRROR = 2'd1,
        SRC_ZERO   = 2'd2,
        SRC_ONES   = 2'd3
    } lane_src_e;
endpackage

// File: rtl/nw_rf_store.sv
module nw_rf_store #(
    parameter int NREGS = 32,
    parameter int NB    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_addr,
    input  logic [NB*8-1:0]          wr_row,
    input  logic [$clog2(NB)-1:0]    wr_len,
    input  logic                     wr_neg,
    input  logic [$clog2(NREGS)-1:0] rd_addr,
    output logic [NB*8-1:0]          rd_row,
    output logic [$clog2(NB)-1:0]    rd_len,
    output logic                     rd_neg
);
    localparam int EL_W = $clog2(NB);

    logic [NB*8-1:0] row_mem [NREGS];
    logic [EL_W-1:0] len_mem [NREGS];
    logic            neg_mem [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                row_mem[i] <= '0;
                len_mem[i] <= '0;
                neg_mem[i] <= 1'b0;
            end
        end else if (wr_en) begin
            row_mem[wr_addr] <= wr_row;
            len_mem[wr_addr] <= wr_len;
            neg_mem[wr_addr] <= wr_neg;
        end
    end

    // asynchronous read sees the pre-edge contents (no bypass)
    always_comb begin
        rd_row = row_mem[rd_addr];
        rd_len = len_mem[rd_addr];
        rd_neg = neg_mem[rd_addr];
    end
endmodule

// File: rtl/nw_rf_lane_mux.sv
module nw_rf_lane_mux
    import nw_rf_pkg::*;
(
    input  lane_src_e  sel,
    input  logic [7:0] direct_byte,
    input  logic [7:0] mirror_byte,
    output logic [7:0] out_byte
);
    always_comb begin
        unique case (sel)
            SRC_DIRECT: out_byte = direct_byte;
            SRC_MIRROR: out_byte = mirror_byte;
            SRC_ZERO:   out_byte = 8'h00;
            SRC_ONES:   out_byte = 8'hFF;
            default:    out_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/nw_rf_read_restore.sv
module nw_rf_read_restore
    import nw_rf_pkg::*;
#(
    parameter int NREGS       = 32,
    parameter int NB          = 4,
    parameter bit MIRROR_ODD  = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_addr,
    input  logic [NB*8-1:0]          wr_row,
    input  logic [$clog2(NB)-1:0]    wr_len,
    input  logic                     wr_neg,
    input  logic                     rd_en,
    input  logic [$clog2(NREGS)-1:0] rd_addr,
    input  logic                     cfg_sign_derived,
    output logic [NB*8-1:0]          rd_data,
    output logic                     rd_valid
);
    localparam int EL_W = $clog2(NB);
    localparam int W    = NB * 8;

    logic [W-1:0]    raw_row;
    logic [EL_W-1:0] raw_len;
    logic            raw_neg;
    logic            mirrored;
    logic [EL_W-1:0] top_lane;
    logic            sign_bit;
    logic [W-1:0]    restored;
    logic [W-1:0]    data_q;
    logic            valid_q;

    nw_rf_store #(.NREGS(NREGS), .NB(NB)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_row  (wr_row),
        .wr_len  (wr_len),
        .wr_neg  (wr_neg),
        .rd_addr (rd_addr),
        .rd_row  (raw_row),
        .rd_len  (raw_len),
        .rd_neg  (raw_neg)
    );

    // sign source selection
    always_comb begin
        mirrored = MIRROR_ODD && rd_addr[0];
        top_lane = mirrored ? (EL_W'(NB - 1) - raw_len) : raw_len;
        sign_bit = cfg_sign_derived ? raw_row[{top_lane, 3'b111}] : raw_neg;
    end

    for (genvar k = 0; k < NB; k++) begin : g_lane
        localparam logic [EL_W:0] LANE_IDX = (EL_W + 1)'(k);
        lane_src_e sel;

        always_comb begin
            if ({1'b0, raw_len} < LANE_IDX)
                sel = sign_bit ? SRC_ONES : SRC_ZERO;
            else
                sel = mirrored ? SRC_MIRROR : SRC_DIRECT;
        end

        nw_rf_lane_mux u_mux (
            .sel         (sel),
            .direct_byte (raw_row[8*k +: 8]),
            .mirror_byte (raw_row[8*(NB-1-k) +: 8]),
            .out_byte    (restored[8*k +: 8])
        );

        if (k > 0) begin : g_chk
            // R3: lanes above the length tag leave as pure fill
            a_r3_fill_uniform: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && ({1'b0, raw_len} < LANE_IDX)) |=>
                    (rd_data[8*k +: 8] == 8'h00 || rd_data[8*k +: 8] == 8'hFF));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_en;
            if (rd_en)
                data_q <= restored;
        end
    end

    assign rd_data  = data_q;
    assign rd_valid = valid_q;

    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data)));

    a_r4_stored_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !cfg_sign_derived && raw_len != EL_W'(NB - 1)) |=>
            (rd_data[W-1] == $past(raw_neg)));
endmodule

// File: tb/tb_nw_rf_read_restore.sv
module tb_nw_rf_read_restore;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [31:0] wr_row;
    logic [1:0]  wr_len;
    logic        wr_neg;
    logic        rd_en;
    logic [4:0]  rd_addr;
    logic        cfg_sign_derived;
    logic [31:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    nw_rf_read_restore dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_row(wr_row), .wr_len(wr_len), .wr_neg(wr_neg), .rd_en(rd_en),
        .rd_addr(rd_addr), .cfg_sign_derived(cfg_sign_derived),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    typedef struct packed {
        logic [4:0]  addr;
        logic [31:0] raw;
        logic [1:0]  len;
        logic        neg;
        logic [31:0] exp_stored;
        logic [31:0] exp_derived;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{5'd2, 32'hAABBCC05, 2'd0, 1'b0, 32'h00000005, 32'h00000005},
        '{5'd2, 32'h11223385, 2'd0, 1'b1, 32'hFFFFFF85, 32'hFFFFFF85},
        '{5'd4, 32'h7F001234, 2'd3, 1'b0, 32'h7F001234, 32'h7F001234},
        '{5'd3, 32'h3412DEAD, 2'd1, 1'b0, 32'h00001234, 32'h00001234},
        '{5'd3, 32'h01805566, 2'd1, 1'b1, 32'hFFFF8001, 32'hFFFF8001},
        '{5'd5, 32'hEFCDAB89, 2'd3, 1'b1, 32'h89ABCDEF, 32'h89ABCDEF},
        '{5'd6, 32'h3CC01122, 2'd2, 1'b1, 32'hFFC01122, 32'hFFC01122},
        '{5'd8, 32'h000000F0, 2'd0, 1'b0, 32'h000000F0, 32'hFFFFFFF0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] r,
                            input logic [1:0] l, input logic n);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_row = r; wr_len = l; wr_neg = n;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] a, input logic sel, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; cfg_sign_derived = sel;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_row = '0; wr_len = '0;
        wr_neg = 1'b0; rd_en = 1'b0; rd_addr = '0; cfg_sign_derived = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'd0, rd_valid}, 32'd0);
        check("R1 data", rd_data, 32'd0);
        do_read(5'd0, 1'b0, d);
        check("R1 row", d, 32'd0);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            do_write(VECS[i].addr, VECS[i].raw, VECS[i].len, VECS[i].neg);
            do_read(VECS[i].addr, 1'b0, d);
            check("R2/R3/R4/R6 stored sign", d, VECS[i].exp_stored);
            check("R7 valid", {31'd0, rd_valid}, 32'd1);
            do_read(VECS[i].addr, 1'b1, d);
            check("R5 derived sign", d, VECS[i].exp_derived);
        end

        // R7: idle cycle holds data and drops valid
        @(negedge clk);
        check("R7 idle valid", {31'd0, rd_valid}, 32'd0);
        check("R7 idle hold", rd_data, VECS[7].exp_derived);

        // R8: same-edge write and read return old contents
        do_write(5'd10, 32'h00000011, 2'd0, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd10; wr_row = 32'h00000022; wr_len = 2'd0; wr_neg = 1'b0;
        rd_en = 1'b1; rd_addr = 5'd10; cfg_sign_derived = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R8 old data", rd_data, 32'h00000011);
        do_read(5'd10, 1'b0, d);
        check("R8 new data", d, 32'h00000022);

        // R6: odd row partner unaffected by even row write
        do_read(5'd5, 1'b0, d);
        check("R6 odd row intact", d, 32'h89ABCDEF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule